// File: doc/BRIEF.md
# Up-Counting Compare PWM Generator

This block produces a single pulse-width-modulated output from a counter that counts up. The counter starts at zero, counts up to a programmable period value inclusive, and then returns to zero. One PWM cycle therefore lasts period+1 clocks. A compare value sets the point in each cycle where the output changes. A one-bit mode input picks the polarity. In the normal mode the output is driven active when the counter returns to zero and inactive when the counter equals the compare value. In the inverted mode both levels are swapped.

The period, compare and mode inputs can be changed at any time. They are captured into active copies only on the clock edge where the counter wraps to zero, so a cycle that is already running is never cut short or stretched. Full-on output needs no special case: it comes from any compare value above the period, which the counter never reaches. When the wrap event and the compare event fall on the same count, the compare (clear) event always wins. A compare value of zero therefore gives a steady inactive output.

The output level comes from a small state machine with three states. PH_IDLE is the reset state. PH_SET is the phase in which the output is at its active level. PH_CLEAR is the phase in which the output is at its inactive level. The transitions are as follows:
- From any state, a compare match moves to PH_CLEAR (clear-on-match).
- From PH_IDLE or PH_CLEAR, a count of zero with no match moves to PH_SET (set-on-wrap).
- In every other case the state holds.

The output is taken from a register that is loaded from the next-state value.

Top module: `pwm_upcmp`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is 0, whatever the other inputs are.
- R2: The counter never exceeds the active period value. With period P, one output cycle is exactly P+1 clocks, so successive rising edges of `pwm_out` are P+1 clocks apart.
- R3: With `invert_in`=0 (set on wrap, clear on match) and compare N where 1 <= N <= P, `pwm_out` is 1 for exactly N clocks of every P+1.
- R4: With `invert_in`=0 and a compare value greater than P, `pwm_out` stays at 1 continuously (full duty). This includes compare = P+1.
- R5: With `invert_in`=0 and compare 0, the set and clear events coincide and the clear wins, so `pwm_out` stays at 0.
- R6: With `invert_in`=1 (clear on wrap, set on match) the output is the complement of R3 to R5. It is 1 for P+1-N of every P+1 clocks, stays 0 for a compare value greater than P, and stays 1 for compare 0.
- R7: Changes to `period_in`, `compare_in` or `invert_in` made in the middle of a cycle do not affect that cycle. They take effect from the cycle that starts at the next wrap.
- R8: Period 0 gives a one-clock cycle. In that case compare 0 gives a steady 0, compare 1 or more gives a steady 1, and with `invert_in`=1 compare 0 gives a steady 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_in | input | W | Requested period value (cycle = value+1 clocks) |
| compare_in | input | W | Requested compare value |
| invert_in | input | 1 | 0: set on wrap, clear on match; 1: inverted |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The two functions that can fall in the same cycle are the set event at count zero and the clear event on a compare match. The bench provokes this overlap with compare 0, both with a normal period and with period 0, and in both polarities. It judges the result by requiring a constant inactive level over several whole cycles, which shows that the clear won. A second overlap is between a register load and a running cycle. The bench changes the compare value right after a rising edge and checks that the high run of that cycle keeps its old length, while the following run takes the new one.

// File: rtl/pwm_upcmp_pkg.sv
package pwm_upcmp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SET   = 2'd1,
        PH_CLEAR = 2'd2
    } phase_e;

    typedef enum logic {
        MODE_SET_CLEAR = 1'b0,
        MODE_CLEAR_SET = 1'b1
    } out_mode_e;

endpackage

// File: rtl/pwm_upcmp_timebase.sv
module pwm_upcmp_timebase
    import pwm_upcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   period_in,
    input  logic [W-1:0]   compare_in,
    input  logic           invert_in,
    output logic [W-1:0]   cnt,
    output logic [W-1:0]   act_period,
    output logic [W-1:0]   act_cmp,
    output out_mode_e      act_mode
);

    localparam logic [W-1:0] ONE = W'(1);

    logic wrap;

    assign wrap = (cnt == act_period);

    // Counter plus shadow capture: the active copies change only on the wrap edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            act_period <= '0;
            act_cmp    <= '0;
            act_mode   <= MODE_SET_CLEAR;
        end else if (wrap) begin
            cnt        <= '0;
            act_period <= period_in;
            act_cmp    <= compare_in;
            act_mode   <= invert_in ? MODE_CLEAR_SET : MODE_SET_CLEAR;
        end else begin
            cnt        <= cnt + ONE;
        end
    end

endmodule

// File: rtl/pwm_upcmp_outfsm.sv
module pwm_upcmp_outfsm
    import pwm_upcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   cnt,
    input  logic [W-1:0]   act_cmp,
    input  out_mode_e      act_mode,
    output logic           pwm_q
);

    phase_e state, nxt;
    logic   set_ev, clr_ev;

    assign set_ev = (cnt == '0);
    assign clr_ev = (cnt == act_cmp);

    // Next phase: a clear event always beats a coincident set event.
    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE:  nxt = clr_ev ? PH_CLEAR : (set_ev ? PH_SET : PH_IDLE);
            PH_SET:   nxt = clr_ev ? PH_CLEAR : PH_SET;
            PH_CLEAR: nxt = clr_ev ? PH_CLEAR : (set_ev ? PH_SET : PH_CLEAR);
            default:  nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    // Registered output decoded from the next phase and the active polarity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            unique case (nxt)
                PH_SET:   pwm_q <= (act_mode == MODE_SET_CLEAR);
                PH_CLEAR: pwm_q <= (act_mode == MODE_CLEAR_SET);
                default:  pwm_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_upcmp.sv
module pwm_upcmp
    import pwm_upcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   period_in,
    input  logic [W-1:0]   compare_in,
    input  logic           invert_in,
    output logic           pwm_out
);

    logic [W-1:0] cnt;
    logic [W-1:0] act_period;
    logic [W-1:0] act_cmp;
    out_mode_e    act_mode;

    pwm_upcmp_timebase #(.W(W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_in  (period_in),
        .compare_in (compare_in),
        .invert_in  (invert_in),
        .cnt        (cnt),
        .act_period (act_period),
        .act_cmp    (act_cmp),
        .act_mode   (act_mode)
    );

    pwm_upcmp_outfsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .act_cmp  (act_cmp),
        .act_mode (act_mode),
        .pwm_q    (pwm_out)
    );

endmodule

// File: rtl/pwm_upcmp_chk.sv
module pwm_upcmp_chk
    import pwm_upcmp_pkg::*;
#(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   cnt,
    input logic [W-1:0]   act_period,
    input logic [W-1:0]   act_cmp,
    input out_mode_e      act_mode,
    input logic           pwm_out
);

    // R1: output low while reset is held
    a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !pwm_out);

    // R2: counter stays within the active period
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period);

    // R7: active copies only change on the edge that returns the counter to zero
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> ($stable(act_period) && $stable(act_cmp) && $stable(act_mode)));

    // R3 / R5: a match in normal polarity drives the output low next cycle
    a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == act_cmp && act_mode == MODE_SET_CLEAR) |=> !pwm_out);

    // R5: compare zero at count zero yields low despite the set event
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && act_cmp == '0 && act_mode == MODE_SET_CLEAR) |=> !pwm_out);

    // R4: unreachable compare keeps the output high from count zero on
    a_r4_full_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && act_cmp > act_period && act_mode == MODE_SET_CLEAR) |=> pwm_out);

    // R6: a match in inverted polarity drives the output high next cycle
    a_r6_match_sets_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == act_cmp && act_mode == MODE_CLEAR_SET) |=> pwm_out);

endmodule

bind pwm_upcmp pwm_upcmp_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .act_period (act_period),
    .act_cmp    (act_cmp),
    .act_mode   (act_mode),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_upcmp_test.sv
module pwm_upcmp_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] period_in = '0;
    logic [W-1:0] compare_in = '0;
    logic         invert_in = 1'b0;
    logic         pwm_out;

    int checks = 0;
    int failures = 0;
    int cur_p = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwm_upcmp #(.W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_in  (period_in),
        .compare_in (compare_in),
        .invert_in  (invert_in),
        .pwm_out    (pwm_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg(input int p, input int c, input bit inv);
        @(negedge clk);
        period_in  = W'(p);
        compare_in = W'(c);
        invert_in  = inv;
        repeat (cur_p + p + 5) @(negedge clk);
        cur_p = p;
    endtask

    task automatic count_high(input int len, output int ones);
        ones = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out) ones++;
        end
    endtask

    task automatic wait_rise();
        bit prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (!prev && pwm_out) break;
            prev = pwm_out;
        end
    endtask

    task automatic t_reset();
        period_in  = 8'd9;
        compare_in = 8'd200;
        invert_in  = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pwm_out == 1'b0, "R1 output during reset", pwm_out, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cur_p = 0;
    endtask

    task automatic t_duty(input int p, input int n);
        int ones;
        apply_cfg(p, n, 1'b0);
        count_high(3 * (p + 1), ones);
        check(ones == 3 * n, $sformatf("R3 duty p=%0d n=%0d", p, n), ones, 3 * n);
    endtask

    task automatic t_period_len(input int p);
        int gap;
        apply_cfg(p, 4, 1'b0);
        wait_rise();
        gap = 0;
        begin
            bit prev;
            prev = pwm_out;
            forever begin
                @(negedge clk);
                gap++;
                if (!prev && pwm_out) break;
                prev = pwm_out;
            end
        end
        check(gap == p + 1, $sformatf("R2 cycle length p=%0d", p), gap, p + 1);
    endtask

    task automatic t_full();
        int ones;
        apply_cfg(9, 200, 1'b0);
        count_high(30, ones);
        check(ones == 30, "R4 compare far above period", ones, 30);
        apply_cfg(9, 10, 1'b0);
        count_high(30, ones);
        check(ones == 30, "R4 compare equal period+1", ones, 30);
    endtask

    task automatic t_zero();
        int ones;
        apply_cfg(9, 0, 1'b0);
        count_high(30, ones);
        check(ones == 0, "R5 compare zero clear wins", ones, 0);
    endtask

    task automatic t_invert();
        int ones;
        apply_cfg(9, 3, 1'b1);
        count_high(30, ones);
        check(ones == 21, "R6 inverted duty n=3", ones, 21);
        apply_cfg(9, 200, 1'b1);
        count_high(30, ones);
        check(ones == 0, "R6 inverted unreachable compare", ones, 0);
        apply_cfg(9, 0, 1'b1);
        count_high(30, ones);
        check(ones == 30, "R6 inverted compare zero", ones, 30);
    endtask

    task automatic t_shadow();
        int run;
        apply_cfg(9, 3, 1'b0);
        wait_rise();
        compare_in = 8'd7;
        run = 1;
        forever begin
            @(negedge clk);
            if (!pwm_out) break;
            run++;
        end
        check(run == 3, "R7 running cycle keeps old compare", run, 3);
        wait_rise();
        invert_in = 1'b1;
        run = 1;
        forever begin
            @(negedge clk);
            if (!pwm_out) break;
            run++;
        end
        check(run == 7, "R7 next cycle uses new compare, mode held", run, 7);
        apply_cfg(9, 7, 1'b0);
    endtask

    task automatic t_period_zero();
        int ones;
        apply_cfg(0, 0, 1'b0);
        count_high(10, ones);
        check(ones == 0, "R8 period 0 compare 0", ones, 0);
        apply_cfg(0, 1, 1'b0);
        count_high(10, ones);
        check(ones == 10, "R8 period 0 compare 1", ones, 10);
        apply_cfg(0, 0, 1'b1);
        count_high(10, ones);
        check(ones == 10, "R8 period 0 inverted compare 0", ones, 10);
    endtask

    initial begin
        t_reset();
        t_duty(99, 25);
        t_duty(9, 1);
        t_duty(9, 9);
        t_duty(99, 99);
        t_period_len(9);
        t_period_len(99);
        t_full();
        t_zero();
        t_invert();
        t_shadow();
        t_period_zero();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule